// File: doc/BRIEF.md
# Byte-Read Emulation Cache over Queued Flash Pages

This block lets a host read flash contents one byte at a time, by arbitrary byte address, although the flash behind it only delivers whole pages. Pages are staged in an SRAM cache by a separate prefetch engine. The SRAM is kept as a ring of slots: new pages join at the tail, and the host uses them up from the head. The block keeps the page number held in each slot. For every host request it splits the byte address into a page number, a 512-byte logical block index (LBA), the LBA position inside the page, and the byte offset.

It then compares the page number against every occupied slot in the same cycle. On a hit it grants the read and presents the SRAM address (slot, offset). The SRAM itself sits outside the block and returns the byte. On a miss it withholds the grant and raises a demand request naming the missing page, so that the fetch side can load that page first.

The head slot is released in three cases. The first is when the host takes the final byte of the head page. The second is when the host is served from a page numbered above the head page. The third is a stall on such a page while the ring is full: without this release no slot could ever open and the stall would never end.

Top module: `nor_emu_cache`

## Requirements
- R1: `rd_lba` equals the byte address shifted right by 9. With 2048-byte pages, `rd_sub` equals address bits [10:9]. With 512-byte pages, `rd_sub` is 0.
- R2: The page number is the address shifted right by log2(PAGE_BYTES). When it equals the page held in an occupied slot and `rd_valid` is high, `rd_ready` is high in that same cycle and `sram_raddr` equals {slot, address modulo PAGE_BYTES}. With `rd_valid` low, neither `rd_ready` nor `dem_valid` is high.
- R3: When `rd_valid` is high and no occupied slot holds the page, `rd_ready` is low and `dem_valid` is high in that same cycle, with `dem_page` equal to the requested page number.
- R4: A fill is taken in a cycle where `fill_valid` and `fill_ready` are both high. `fill_slot` names the tail slot that the fill occupies. Slots are handed out in the order 0, 1, 2 and so on, wrapping from DEPTH-1 back to 0.
- R5: With DEPTH slots occupied, `fill_ready` is low. A fill offered then is not taken: its page stays absent and `fill_slot` does not move.
- R6: A granted read of the last byte of the head page (offset PAGE_BYTES-1) releases the head slot. That page misses from the next cycle on.
- R7: A granted read of a page numbered higher than the head page releases the head slot.
- R8: When all slots are occupied and a read misses on a page numbered higher than the head page, the head slot is released and `fill_ready` is high in the next cycle.
- R9: After reset the ring is empty: `fill_ready` is 1, `fill_slot` is 0, and every read misses.
- R10: Reads of the head page at any offset other than the last do not release it. Reads of lower-numbered pages and misses with the ring not full release nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Host read request |
| rd_addr | input | ADDR_W | Host byte address |
| rd_ready | output | 1 | Read granted (page present) |
| rd_lba | output | ADDR_W-9 | Logical block index of the address |
| rd_sub | output | SUB_W | LBA position inside the page |
| sram_raddr | output | SLOT_W+PAGE_SH | SRAM byte address {slot, offset} |
| dem_valid | output | 1 | Demand fetch request for a missing page |
| dem_page | output | ADDR_W-PAGE_SH | Page number demanded |
| fill_valid | input | 1 | Prefetch engine offers a page |
| fill_page | input | ADDR_W-PAGE_SH | Page number being filled |
| fill_ready | output | 1 | Ring has a free slot |
| fill_slot | output | SLOT_W | Tail slot the next fill occupies |

## Verification
A slot whose valid bit or page number is corrupted shows up on the very next read of that page. A present page is reported as a miss, with a demand request raised in the same cycle, or an absent page is granted with a wrong slot in `sram_raddr`. Head and tail pointer faults show up on `fill_slot` at the next fill and on `fill_ready` once the ring fills. A release in the wrong cycle makes the next read of the dropped or kept page flip between hit and miss one cycle after the triggering read.

// File: rtl/nec_pkg.sv
package nec_pkg;
  // One logical block is 512 bytes.
  localparam int LBA_SH = 9;

  // Why the head slot is released in a cycle.
  typedef enum logic [1:0] {
    DQ_NONE   = 2'd0,
    DQ_LAST   = 2'd1,
    DQ_PAST   = 2'd2,
    DQ_FORCED = 2'd3
  } deq_cause_e;
endpackage

// File: rtl/nec_addr_split.sv
module nec_addr_split #(
  parameter int ADDR_W  = 20,
  parameter int PAGE_SH = 9,
  parameter int SUB_W   = 1,
  localparam int PN_W   = ADDR_W - PAGE_SH,
  localparam int LBA_W  = ADDR_W - nec_pkg::LBA_SH
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [PN_W-1:0]    page_o,
  output logic [PAGE_SH-1:0] off_o,
  output logic [LBA_W-1:0]   lba_o,
  output logic [SUB_W-1:0]   sub_o
);
  import nec_pkg::*;

  assign page_o = addr_i[ADDR_W-1:PAGE_SH];
  assign off_o  = addr_i[PAGE_SH-1:0];
  assign lba_o  = addr_i[ADDR_W-1:LBA_SH];

  // Pages larger than one LBA carry LBA-select bits; otherwise zero.
  generate
    if (PAGE_SH > LBA_SH) begin : g_multi_lba
      assign sub_o = addr_i[PAGE_SH-1:LBA_SH];
    end else begin : g_single_lba
      assign sub_o = '0;
    end
  endgenerate
endmodule

// File: rtl/nec_queue.sv
module nec_queue #(
  parameter int DEPTH  = 8,
  parameter int PN_W   = 11,
  localparam int SLOT_W = $clog2(DEPTH),
  localparam int CNT_W  = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_i,
  input  logic [PN_W-1:0]   enq_page_i,
  input  logic              deq_i,
  input  logic [PN_W-1:0]   look_page_i,
  output logic [DEPTH-1:0]  match_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [SLOT_W-1:0] head_o,
  output logic [SLOT_W-1:0] tail_o,
  output logic [PN_W-1:0]   head_page_o
);
  logic [PN_W-1:0]   pn_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [SLOT_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [SLOT_W-1:0] ring_next(input logic [SLOT_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full_o      = (int'(cnt_q) == DEPTH);
  assign empty_o     = (cnt_q == '0);
  assign head_o      = head_q;
  assign tail_o      = tail_q;
  assign head_page_o = pn_q[head_q];

  // Parallel compare of the looked-up page against every slot.
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match_o[g] = vld_q[g] && (pn_q[g] == look_page_i);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      vld_q  <= '0;
      for (int i = 0; i < DEPTH; i++) pn_q[i] <= '0;
    end else begin
      if (enq_i) begin
        pn_q[tail_q]  <= enq_page_i;
        vld_q[tail_q] <= 1'b1;
        tail_q        <= ring_next(tail_q);
      end
      if (deq_i) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= ring_next(head_q);
      end
      case ({enq_i, deq_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH); // R5
  AST_NO_ENQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(enq_i && full_o)); // R5
  AST_DEQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    deq_i |-> !empty_o); // R6
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_i && !deq_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
  AST_VALID_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q)); // R6
endmodule

// File: rtl/nec_match_enc.sv
module nec_match_enc #(
  parameter int DEPTH  = 8,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]  match_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o
);
  assign hit_o = |match_i;

  // Lowest matching slot wins.
  always_comb begin
    slot_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_i[i]) slot_o = SLOT_W'(i);
    end
  end

  always_comb begin
    if (hit_o) begin
      AST_SLOT_MATCHES: assert (match_i[slot_o]); // R2
    end
  end
endmodule

// File: rtl/nor_emu_cache.sv
module nor_emu_cache #(
  parameter int ADDR_W     = 20,
  parameter int PAGE_BYTES = 512,
  parameter int DEPTH      = 8,
  localparam int PAGE_SH   = $clog2(PAGE_BYTES),
  localparam int PN_W      = ADDR_W - PAGE_SH,
  localparam int LBA_W     = ADDR_W - nec_pkg::LBA_SH,
  localparam int SUB_W     = (PAGE_SH > nec_pkg::LBA_SH) ? PAGE_SH - nec_pkg::LBA_SH : 1,
  localparam int SLOT_W    = $clog2(DEPTH),
  localparam int SRAM_AW   = SLOT_W + PAGE_SH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_valid,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_ready,
  output logic [LBA_W-1:0]   rd_lba,
  output logic [SUB_W-1:0]   rd_sub,
  output logic [SRAM_AW-1:0] sram_raddr,
  output logic               dem_valid,
  output logic [PN_W-1:0]    dem_page,
  input  logic               fill_valid,
  input  logic [PN_W-1:0]    fill_page,
  output logic               fill_ready,
  output logic [SLOT_W-1:0]  fill_slot
);
  import nec_pkg::*;

  logic [PN_W-1:0]    req_page;
  logic [PAGE_SH-1:0] req_off;
  logic [DEPTH-1:0]   match;
  logic               any_hit, q_full, q_empty;
  logic [SLOT_W-1:0]  hit_slot, head_slot, tail_slot;
  logic [PN_W-1:0]    head_page;
  logic               enq, deq;
  logic               ev_last_byte, ev_past_head;
  deq_cause_e         deq_cause;

  nec_addr_split #(.ADDR_W(ADDR_W), .PAGE_SH(PAGE_SH), .SUB_W(SUB_W)) u_split (
    .addr_i (rd_addr),
    .page_o (req_page),
    .off_o  (req_off),
    .lba_o  (rd_lba),
    .sub_o  (rd_sub)
  );

  nec_queue #(.DEPTH(DEPTH), .PN_W(PN_W)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_i       (enq),
    .enq_page_i  (fill_page),
    .deq_i       (deq),
    .look_page_i (req_page),
    .match_o     (match),
    .full_o      (q_full),
    .empty_o     (q_empty),
    .head_o      (head_slot),
    .tail_o      (tail_slot),
    .head_page_o (head_page)
  );

  nec_match_enc #(.DEPTH(DEPTH)) u_enc (
    .match_i (match),
    .hit_o   (any_hit),
    .slot_o  (hit_slot)
  );

  function automatic logic is_last_byte(input logic [PAGE_SH-1:0] off);
    return &off;
  endfunction

  // Host side
  assign rd_ready   = rd_valid && any_hit;
  assign sram_raddr = {hit_slot, req_off};
  assign dem_valid  = rd_valid && !any_hit;
  assign dem_page   = req_page;

  // Named release events
  assign ev_last_byte = rd_ready && (hit_slot == head_slot) && is_last_byte(req_off);
  assign ev_past_head = rd_valid && !q_empty && (req_page > head_page);

  always_comb begin
    if (ev_last_byte)                       deq_cause = DQ_LAST;
    else if (ev_past_head && rd_ready)      deq_cause = DQ_PAST;
    else if (ev_past_head && q_full)        deq_cause = DQ_FORCED;
    else                                    deq_cause = DQ_NONE;
  end
  assign deq = (deq_cause != DQ_NONE);

  // Fill side
  assign fill_ready = !q_full;
  assign fill_slot  = tail_slot;
  assign enq        = fill_valid && fill_ready;

  AST_GRANT_XOR_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_ready != dem_valid)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (!rd_ready && !dem_valid)); // R2
  AST_DEQ_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    deq |-> rd_valid); // R7
  AST_REFUSED_TAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> $stable(fill_slot)); // R5
  AST_FORCED_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_cause == DQ_FORCED && !fill_valid) |=> fill_ready); // R8
endmodule

// File: tb/nor_emu_cache_bench.sv
module nor_emu_cache_bench;
  localparam int ADDR_W = 20;
  localparam int PB     = 2048;
  localparam int DEPTH  = 8;
  localparam int PSH    = 11;
  localparam int PN_W   = ADDR_W - PSH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_valid = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic rd_ready;
  logic [ADDR_W-10:0] rd_lba;
  logic [1:0] rd_sub;
  logic [13:0] sram_raddr;
  logic dem_valid;
  logic [PN_W-1:0] dem_page;
  logic fill_valid = 1'b0;
  logic [PN_W-1:0] fill_page = '0;
  logic fill_ready;
  logic [2:0] fill_slot;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nor_emu_cache #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .DEPTH(DEPTH)) u_nor_emu_cache (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_lba(rd_lba), .rd_sub(rd_sub), .sram_raddr(sram_raddr),
    .dem_valid(dem_valid), .dem_page(dem_page), .fill_valid(fill_valid),
    .fill_page(fill_page), .fill_ready(fill_ready), .fill_slot(fill_slot)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Read at one address; checks grant, demand and address split.
  task automatic do_read(input string req, input int addr, input bit exp_hit, input int exp_slot);
    @(negedge clk);
    rd_valid = 1'b1;
    rd_addr  = addr[ADDR_W-1:0];
    #2;
    chk({req, " ready"}, int'(rd_ready), int'(exp_hit));
    chk({req, " demand"}, int'(dem_valid), int'(!exp_hit));
    if (exp_hit) chk({req, " sram"}, int'(sram_raddr), (exp_slot << PSH) | (addr % PB));
    else         chk({req, " dem_page"}, int'(dem_page), addr >> PSH);
    chk("R1 lba", int'(rd_lba), addr >> 9);
    chk("R1 sub", int'(rd_sub), (addr >> 9) & 3);
    @(posedge clk);
    #1 rd_valid = 1'b0;
  endtask

  task automatic do_fill(input string req, input int page, input bit exp_rdy, input int exp_slot);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_page  = page[PN_W-1:0];
    #2;
    chk({req, " fill_ready"}, int'(fill_ready), int'(exp_rdy));
    chk({req, " fill_slot"}, int'(fill_slot), exp_slot);
    @(posedge clk);
    #1 fill_valid = 1'b0;
  endtask

  // {expect hit, address}; pages 5,6,7 sit in slots 0,1,2 when walked.
  localparam int NV = 6;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 20'h02800}, {1'b1, 20'h02A05}, {1'b1, 20'h02FFE},
    {1'b0, 20'h01900}, {1'b0, 20'h04C10}, {1'b1, 20'h02C00}
  };

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 fill_ready", int'(fill_ready), 1);
    chk("R9 fill_slot", int'(fill_slot), 0);
    do_read("R9", 32'h02800, 1'b0, 0);

    // R4: fills go to slots in order
    do_fill("R4", 5, 1'b1, 0);
    do_fill("R4", 6, 1'b1, 1);
    do_fill("R4", 7, 1'b1, 2);

    // R2/R3/R10: table walk
    for (int i = 0; i < NV; i++) begin
      do_read(VEC[i][20] ? "R2" : "R3", int'(VEC[i][19:0]), VEC[i][20], 0);
    end
    do_read("R10", 32'h02801, 1'b1, 0);

    // R6: last byte of head page releases it
    do_read("R6", 32'h02FFF, 1'b1, 0);
    do_read("R6", 32'h02800, 1'b0, 0);

    // R7: read of a higher page releases head (page 6)
    do_read("R7", 32'h03800, 1'b1, 2);
    do_read("R7", 32'h03000, 1'b0, 0);

    // R5: fill to full, then a refused fill
    for (int p = 10; p < 17; p++) do_fill("R4", p, 1'b1, (p - 7) % DEPTH);
    do_fill("R5", 20, 1'b0, 2);

    // R8: full + miss on higher page drops head (page 7)
    do_read("R5", 32'h0A000, 1'b0, 0);
    @(negedge clk);
    chk("R8 fill_ready", int'(fill_ready), 1);
    chk("R4 wrap slot", int'(fill_slot), 2);
    do_read("R8", 32'h03800, 1'b0, 0);
    do_read("R10", 32'h05000, 1'b1, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule